// File: doc/BRIEF.md
# Stack Bytecode Folding Decoder

This block sits at the front of a stack-machine pipeline. It takes a byte-aligned stream of variable-length instructions, arriving in beats of several bytes under a valid/ready handshake, and gathers them in a small fetch buffer. Each clock it decodes at most one instruction from the head of the buffer and issues a decoded record. The record holds the opcode, where each operand comes from (a stack-cache slot or a local-variable index), the length consumed and a fold flag.

When a local-variable load is directly followed in the buffer by an integer arithmetic or logic instruction that uses the loaded value, the two are issued together as one folded record. The loaded value is then named by its local index, and no push onto the stack takes place. The decoder keeps a top-of-stack pointer over a 64-entry stack cache. That pointer is used to name stack slots and moves by the net stack effect of each record.

Encodings (byte values): filler 0x00 (one byte); short loads 0x10 to 0x13 (one byte, local index 0 to 3); indexed load 0x14 followed by an 8-bit index byte; ALU operations 0x20 add, 0x21 sub, 0x22 and, 0x23 or, 0x24 xor (one byte each). Every other byte value is illegal. The first byte of a beat sits in `in_data[7:0]`.

Top module: `fold_decoder`

## Requirements
- R1: After reset `out_valid` is 0, `out_tos` is 0 and `in_ready` is 1.
- R2: A short load 0x10+k that is not folded issues a record with op 0x10+k, length 1, fold 0, operand A = local k (`out_a_local`=1), and increments `out_tos` by 1.
- R3: An indexed load 0x14 waits until its index byte is in the buffer. Unfolded, it issues a record with length 2, operand A = local <index byte>, and increments `out_tos`.
- R4: A load followed in the buffer by an ALU op (0x20 to 0x24) is issued as one record with fold 1, op = the ALU opcode, length = load length + 1, operand A = stack slot tos-1 (`out_a_local`=0), operand B = local index (`out_b_local`=1), and `out_tos` unchanged.
- R5: An unfolded ALU op issues length 1, fold 0, operand A = slot tos-2, operand B = slot tos-1 (both `*_local`=0), and decrements `out_tos` by 1.
- R6: A load whose following instruction byte is not yet in the buffer is issued unfolded. The ALU op that arrives later issues unfolded.
- R7: For load, load, ALU op, the first load issues as a plain push and only the second load folds with the ALU op.
- R8: An illegal byte issues one record with `out_illegal`=1, op = that byte, length 1, fold 0, and `out_tos` unchanged. Decoding resumes at the very next byte.
- R9: At most one record issues per clock. Filler bytes are consumed without a record, and `out_tos` holds while no record issues.
- R10: The top-of-stack pointer and the slot indices wrap modulo 64.
- R11: `in_ready` is low while the buffer holds more than 8 minus 4 bytes, so a beat is never accepted without room.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input beat valid |
| in_data | input | 32 | Four instruction bytes, first byte in bits 7:0 |
| in_ready | output | 1 | Beat accepted on a clock edge when high with in_valid |
| out_valid | output | 1 | Decoded record valid for this cycle |
| out_op | output | 8 | Issued opcode (ALU opcode when folded) |
| out_len | output | 4 | Bytes consumed by this record |
| out_fold | output | 1 | Record is a folded load plus ALU op |
| out_illegal | output | 1 | Record is an illegal byte |
| out_a_local | output | 1 | Operand A is a local index (1) or a stack slot (0) |
| out_a_idx | output | 8 | Operand A index |
| out_b_local | output | 1 | Operand B is a local index (1) or a stack slot (0) |
| out_b_idx | output | 8 | Operand B index |
| out_tos | output | 6 | Top-of-stack pointer after the latest record |

## Verification
A fetch buffer that shifts by the wrong amount shows up in the next record as a wrong opcode or a misread index. Once the stream is misaligned, every later record in the run is wrong. A wrong top-of-stack pointer shows at once in `out_tos` and, from the next ALU record on, in the slot indices, so pushes, folds and pops are checked against a running count kept by the bench. A wrong fold decision changes the record count and the length field of the very record involved, and the tests that split a pair across beats, chain two loads and cross the 64-entry wrap target exactly those decisions.

// File: rtl/fold_pkg.sv
package fold_pkg;

  typedef logic [3:0] len_t;

  localparam logic [7:0] OPC_FILL = 8'h00;
  localparam logic [7:0] OPC_LDX  = 8'h14;
  localparam logic [7:0] OPC_ADD  = 8'h20;
  localparam logic [7:0] OPC_XOR  = 8'h24;

  typedef struct packed {
    logic [7:0] op;
    len_t       len;
    logic       fold;
    logic       illegal;
    logic       a_loc;
    logic [7:0] a_idx;
    logic       b_loc;
    logic [7:0] b_idx;
  } dec_rec_t;

  function automatic logic is_ld_short(input logic [7:0] b);
    return b[7:2] == 6'b000100;
  endfunction

  function automatic logic is_alu(input logic [7:0] b);
    return (b >= OPC_ADD) && (b <= OPC_XOR);
  endfunction

endpackage

// File: rtl/rst_sync.sv
module rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_sync = sync_q[1];
endmodule

// File: rtl/fetch_buf.sv
module fetch_buf
  import fold_pkg::*;
#(
  parameter int BUF_BYTES  = 8,
  parameter int IN_BYTES   = 4,
  parameter int LOOK_BYTES = 3,
  localparam int CW = $clog2(BUF_BYTES + 1),
  localparam int PW = $clog2(BUF_BYTES)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  input  logic [IN_BYTES*8-1:0]   in_data,
  output logic                    in_ready,
  input  len_t                    consume,
  output logic [LOOK_BYTES*8-1:0] head,
  output logic [CW-1:0]           cnt
);
  logic [BUF_BYTES-1:0][7:0] mem_q, mem_d;
  logic [CW-1:0]             cnt_q, cnt_d, keep;
  logic                      acc, upd;

  assign in_ready = (cnt_q <= CW'(BUF_BYTES - IN_BYTES));
  assign acc      = in_valid && in_ready;
  assign upd      = acc || (consume != '0);
  assign keep     = cnt_q - CW'(consume);

  always_comb begin
    for (int i = 0; i < BUF_BYTES; i++) begin
      int src;
      src = i + int'(consume);
      mem_d[i] = 8'h00;
      if (src < BUF_BYTES) mem_d[i] = mem_q[src[PW-1:0]];
      if (acc && (i >= int'(keep)) && (i < int'(keep) + IN_BYTES))
        mem_d[i] = in_data[(i - int'(keep))*8 +: 8];
    end
    cnt_d = keep + (acc ? CW'(IN_BYTES) : '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_q <= '0;
      cnt_q <= '0;
    end else if (upd) begin
      mem_q <= mem_d;
      cnt_q <= cnt_d;
    end
  end

  generate
    for (genvar g = 0; g < LOOK_BYTES; g++) begin : g_head
      assign head[g*8 +: 8] = mem_q[g];
    end
  endgenerate

  assign cnt = cnt_q;
endmodule

// File: rtl/fold_decode.sv
module fold_decode
  import fold_pkg::*;
#(
  parameter int TOS_W     = 6,
  parameter int BUF_BYTES = 8,
  localparam int CW = $clog2(BUF_BYTES + 1)
) (
  input  logic [23:0]      head,
  input  logic [CW-1:0]    cnt,
  input  logic [TOS_W-1:0] tos,
  output logic             issue,
  output dec_rec_t         rec,
  output len_t             consume,
  output logic [TOS_W-1:0] tos_nxt
);
  logic [7:0]       b0, b1, b2;
  logic [TOS_W-1:0] tos_m1, tos_m2;

  assign b0     = head[7:0];
  assign b1     = head[15:8];
  assign b2     = head[23:16];
  assign tos_m1 = tos - TOS_W'(1);
  assign tos_m2 = tos - TOS_W'(2);

  always_comb begin
    issue   = 1'b0;
    rec     = '0;
    consume = '0;
    tos_nxt = tos;
    if (cnt >= CW'(1)) begin
      if (is_ld_short(b0)) begin
        issue = 1'b1;
        if ((cnt >= CW'(2)) && is_alu(b1)) begin
          rec.op    = b1;
          rec.len   = 4'd2;
          rec.fold  = 1'b1;
          rec.a_idx = 8'(tos_m1);
          rec.b_loc = 1'b1;
          rec.b_idx = {6'b0, b0[1:0]};
        end else begin
          rec.op    = b0;
          rec.len   = 4'd1;
          rec.a_loc = 1'b1;
          rec.a_idx = {6'b0, b0[1:0]};
          tos_nxt   = tos + TOS_W'(1);
        end
      end else if (b0 == OPC_LDX) begin
        if (cnt >= CW'(2)) begin
          issue = 1'b1;
          if ((cnt >= CW'(3)) && is_alu(b2)) begin
            rec.op    = b2;
            rec.len   = 4'd3;
            rec.fold  = 1'b1;
            rec.a_idx = 8'(tos_m1);
            rec.b_loc = 1'b1;
            rec.b_idx = b1;
          end else begin
            rec.op    = b0;
            rec.len   = 4'd2;
            rec.a_loc = 1'b1;
            rec.a_idx = b1;
            tos_nxt   = tos + TOS_W'(1);
          end
        end
      end else if (is_alu(b0)) begin
        issue     = 1'b1;
        rec.op    = b0;
        rec.len   = 4'd1;
        rec.a_idx = 8'(tos_m2);
        rec.b_idx = 8'(tos_m1);
        tos_nxt   = tos_m1;
      end else if (b0 == OPC_FILL) begin
        rec.len = 4'd1;
      end else begin
        issue       = 1'b1;
        rec.op      = b0;
        rec.len     = 4'd1;
        rec.illegal = 1'b1;
      end
    end
    consume = rec.len;
  end
endmodule

// File: rtl/stack_ptr.sv
module stack_ptr #(
  parameter int TOS_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [TOS_W-1:0] tos_nxt,
  output logic [TOS_W-1:0] tos
);
  logic [TOS_W-1:0] tos_q, tos_d;

  always_comb tos_d = en ? tos_nxt : tos_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tos_q <= '0;
    else        tos_q <= tos_d;
  end

  assign tos = tos_q;
endmodule

// File: rtl/fold_decoder.sv
module fold_decoder
  import fold_pkg::*;
#(
  parameter int BUF_BYTES = 8,
  parameter int IN_BYTES  = 4,
  parameter int SC_DEPTH  = 64,
  localparam int TOS_W = $clog2(SC_DEPTH),
  localparam int CW    = $clog2(BUF_BYTES + 1)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  in_valid,
  input  logic [IN_BYTES*8-1:0] in_data,
  output logic                  in_ready,
  output logic                  out_valid,
  output logic [7:0]            out_op,
  output logic [3:0]            out_len,
  output logic                  out_fold,
  output logic                  out_illegal,
  output logic                  out_a_local,
  output logic [7:0]            out_a_idx,
  output logic                  out_b_local,
  output logic [7:0]            out_b_idx,
  output logic [TOS_W-1:0]      out_tos
);
  logic             rst_ni;
  logic [23:0]      head;
  logic [CW-1:0]    cnt;
  logic [TOS_W-1:0] tos, tos_nxt;
  logic             issue;
  dec_rec_t         rec, rec_q;
  len_t             consume;
  logic             valid_q;

  rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_n_sync(rst_ni));

  fetch_buf #(.BUF_BYTES(BUF_BYTES), .IN_BYTES(IN_BYTES), .LOOK_BYTES(3)) u_buf (
    .clk(clk), .rst_n(rst_ni), .in_valid(in_valid), .in_data(in_data),
    .in_ready(in_ready), .consume(consume), .head(head), .cnt(cnt)
  );

  fold_decode #(.TOS_W(TOS_W), .BUF_BYTES(BUF_BYTES)) u_dec (
    .head(head), .cnt(cnt), .tos(tos), .issue(issue), .rec(rec),
    .consume(consume), .tos_nxt(tos_nxt)
  );

  stack_ptr #(.TOS_W(TOS_W)) u_sp (
    .clk(clk), .rst_n(rst_ni), .en(issue), .tos_nxt(tos_nxt), .tos(tos)
  );

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) valid_q <= 1'b0;
    else         valid_q <= issue;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni)    rec_q <= '0;
    else if (issue) rec_q <= rec;
  end

  assign out_valid   = valid_q;
  assign out_op      = rec_q.op;
  assign out_len     = rec_q.len;
  assign out_fold    = rec_q.fold;
  assign out_illegal = rec_q.illegal;
  assign out_a_local = rec_q.a_loc;
  assign out_a_idx   = rec_q.a_idx;
  assign out_b_local = rec_q.b_loc;
  assign out_b_idx   = rec_q.b_idx;
  assign out_tos     = tos;
endmodule

// File: rtl/fold_decoder_chk.sv
module fold_decoder_chk #(
  parameter int TOS_W = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             out_valid,
  input logic [7:0]       out_op,
  input logic [3:0]       out_len,
  input logic             out_fold,
  input logic             out_illegal,
  input logic             out_a_local,
  input logic [7:0]       out_a_idx,
  input logic             out_b_local,
  input logic [7:0]       out_b_idx,
  input logic [TOS_W-1:0] out_tos
);
  logic is_load, is_alu_op;
  assign is_load   = (out_op >= 8'h10) && (out_op <= 8'h14);
  assign is_alu_op = (out_op >= 8'h20) && (out_op <= 8'h24);

  // R8
  illegal_plain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_illegal) |-> (!out_fold && out_len == 4'd1 && out_tos == $past(out_tos)));

  // R4
  fold_keeps_tos_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_fold) |-> (out_tos == $past(out_tos) && !out_a_local && out_b_local
                                 && is_alu_op && (out_len == 4'd2 || out_len == 4'd3)));

  // R2
  load_push_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_fold && !out_illegal && is_load) |-> (out_tos == TOS_W'($past(out_tos) + 1'b1)));

  // R5
  alu_slots_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_fold && is_alu_op) |->
      (out_b_idx[TOS_W-1:0] == TOS_W'(out_a_idx[TOS_W-1:0] + 1'b1) && out_b_idx[TOS_W-1:0] == out_tos));

  // R9
  quiet_tos_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> $stable(out_tos));
endmodule

bind fold_decoder fold_decoder_chk #(.TOS_W(TOS_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .out_valid(out_valid), .out_op(out_op), .out_len(out_len),
  .out_fold(out_fold), .out_illegal(out_illegal), .out_a_local(out_a_local),
  .out_a_idx(out_a_idx), .out_b_local(out_b_local), .out_b_idx(out_b_idx), .out_tos(out_tos)
);

// File: tb/fold_decoder_bench.sv
module fold_decoder_bench;
  logic        clk;
  logic        rst_n;
  logic        in_valid;
  logic [31:0] in_data;
  logic        in_ready;
  logic        out_valid;
  logic [7:0]  out_op;
  logic [3:0]  out_len;
  logic        out_fold, out_illegal, out_a_local, out_b_local;
  logic [7:0]  out_a_idx, out_b_idx;
  logic [5:0]  out_tos;

  int checks = 0;
  int errors = 0;
  int tos_m  = 0;
  logic [37:0] q[$];

  fold_decoder u_fold_decoder (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
    .out_valid(out_valid), .out_op(out_op), .out_len(out_len), .out_fold(out_fold),
    .out_illegal(out_illegal), .out_a_local(out_a_local), .out_a_idx(out_a_idx),
    .out_b_local(out_b_local), .out_b_idx(out_b_idx), .out_tos(out_tos)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  always @(negedge clk)
    if (rst_n && out_valid)
      q.push_back({out_op, out_len, out_fold, out_illegal, out_a_local, out_a_idx,
                   out_b_local, out_b_idx, out_tos});

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic exp_rec(input string tag, input logic [7:0] op, input logic [3:0] len,
                         input logic fold, input logic ill, input logic al, input logic [7:0] ai,
                         input logic bl, input logic [7:0] bi, input int tos);
    logic [37:0] e;
    e = {op, len, fold, ill, al, ai, bl, bi, tos[5:0]};
    checks++;
    if (q.size() == 0) begin
      errors++;
      $display("FAIL %s: actual no record expected %h", tag, e);
    end else begin
      logic [37:0] a;
      a = q.pop_front();
      if (a !== e) begin
        errors++;
        $display("FAIL %s: actual %h expected %h", tag, a, e);
      end
    end
  endtask

  // called at a falling edge, returns at a falling edge
  task automatic send_beat(input logic [7:0] b0, input logic [7:0] b1,
                           input logic [7:0] b2, input logic [7:0] b3);
    while (!in_ready) begin
      in_valid = 1'b0;
      @(negedge clk);
    end
    in_valid = 1'b1;
    in_data  = {b3, b2, b1, b0};
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic drain();
    repeat (20) @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R1 out_valid", 64'(out_valid), 64'd0);
    chk("R1 out_tos", 64'(out_tos), 64'd0);
    chk("R1 in_ready", 64'(in_ready), 64'd1);
  endtask

  task automatic t_loads();
    send_beat(8'h11, 8'h14, 8'h37, 8'h00);
    drain();
    tos_m++; exp_rec("R2 short load", 8'h11, 4'd1, 0, 0, 1, 8'd1, 0, 8'd0, tos_m);
    tos_m++; exp_rec("R3 indexed load", 8'h14, 4'd2, 0, 0, 1, 8'h37, 0, 8'd0, tos_m);
  endtask

  task automatic t_alu();
    send_beat(8'h21, 8'h00, 8'h00, 8'h00);
    drain();
    exp_rec("R5 unfolded sub", 8'h21, 4'd1, 0, 0, 0, 8'(tos_m - 2), 0, 8'(tos_m - 1), tos_m - 1);
    tos_m--;
  endtask

  task automatic t_fold();
    send_beat(8'h12, 8'h20, 8'h00, 8'h00);
    drain();
    exp_rec("R4 fold short", 8'h20, 4'd2, 1, 0, 0, 8'(tos_m - 1), 1, 8'd2, tos_m);
    send_beat(8'h14, 8'h99, 8'h24, 8'h00);
    drain();
    exp_rec("R4 fold indexed", 8'h24, 4'd3, 1, 0, 0, 8'(tos_m - 1), 1, 8'h99, tos_m);
  endtask

  task automatic t_split();
    send_beat(8'h00, 8'h00, 8'h00, 8'h13);
    drain();
    tos_m++; exp_rec("R6 load alone", 8'h13, 4'd1, 0, 0, 1, 8'd3, 0, 8'd0, tos_m);
    chk("R6 no extra record", 64'(q.size()), 64'd0);
    send_beat(8'h23, 8'h00, 8'h00, 8'h00);
    drain();
    exp_rec("R6 late or", 8'h23, 4'd1, 0, 0, 0, 8'(tos_m - 2), 0, 8'(tos_m - 1), tos_m - 1);
    tos_m--;
    send_beat(8'h00, 8'h00, 8'h00, 8'h14);
    drain();
    chk("R3 waits for index", 64'(q.size()), 64'd0);
    send_beat(8'h42, 8'h22, 8'h00, 8'h00);
    drain();
    exp_rec("R3 indexed fold after wait", 8'h22, 4'd3, 1, 0, 0, 8'(tos_m - 1), 1, 8'h42, tos_m);
  endtask

  task automatic t_chain();
    send_beat(8'h10, 8'h11, 8'h22, 8'h00);
    drain();
    tos_m++; exp_rec("R7 first load push", 8'h10, 4'd1, 0, 0, 1, 8'd0, 0, 8'd0, tos_m);
    exp_rec("R7 second load folds", 8'h22, 4'd2, 1, 0, 0, 8'(tos_m - 1), 1, 8'd1, tos_m);
  endtask

  task automatic t_illegal();
    send_beat(8'h7E, 8'h10, 8'h25, 8'h00);
    drain();
    exp_rec("R8 illegal 7E", 8'h7E, 4'd1, 0, 1, 0, 8'd0, 0, 8'd0, tos_m);
    tos_m++; exp_rec("R8 resume load", 8'h10, 4'd1, 0, 0, 1, 8'd0, 0, 8'd0, tos_m);
    exp_rec("R8 illegal 25", 8'h25, 4'd1, 0, 1, 0, 8'd0, 0, 8'd0, tos_m);
    chk("R9 filler no record", 64'(q.size()), 64'd0);
  endtask

  task automatic t_ready();
    send_beat(8'h10, 8'h10, 8'h10, 8'h10);
    chk("R11 ready with 4 held", 64'(in_ready), 64'd1);
    send_beat(8'h10, 8'h10, 8'h10, 8'h10);
    chk("R11 not ready with 7 held", 64'(in_ready), 64'd0);
    drain();
    for (int i = 0; i < 8; i++) begin
      tos_m++; exp_rec("R11 queued load", 8'h10, 4'd1, 0, 0, 1, 8'd0, 0, 8'd0, tos_m % 64);
    end
    chk("R9 one record per load", 64'(q.size()), 64'd0);
  endtask

  task automatic push_loads(input int n);
    int left;
    left = n;
    while (left > 0) begin
      send_beat(8'h10, (left > 1) ? 8'h10 : 8'h00, (left > 2) ? 8'h10 : 8'h00,
                (left > 3) ? 8'h10 : 8'h00);
      left -= 4;
    end
    drain();
    for (int i = 0; i < n; i++) begin
      tos_m = (tos_m + 1) % 64;
      exp_rec("R10 wrapping load", 8'h10, 4'd1, 0, 0, 1, 8'd0, 0, 8'd0, tos_m);
    end
  endtask

  task automatic t_wrap();
    push_loads(54);
    chk("R10 tos wrapped", 64'(out_tos), 64'd1);
    send_beat(8'h21, 8'h00, 8'h00, 8'h00);
    drain();
    exp_rec("R10 slots wrap", 8'h21, 4'd1, 0, 0, 0, 8'd63, 0, 8'd0, 0);
    tos_m = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n    = 1'b0;
    in_valid = 1'b0;
    in_data  = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    t_reset();
    t_loads();
    t_alu();
    t_fold();
    t_split();
    t_chain();
    t_illegal();
    t_ready();
    t_wrap();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule